// File: doc/BRIEF.md
# Recirculating Shuffle-Exchange Key Sorter

This block sorts N unsigned keys with a single column of N/2 programmable compare-exchange cells and N key registers. The registers and the cells form a closed loop. Every clock cycle the register contents are reordered by a fixed perfect shuffle, pass through the cell column, and are written back. A small schedule unit picks a mode for each cell on every pass: pass through unchanged, minimum to the upper output, or minimum to the lower output. Over log2(N)^2 passes these modes carry out a complete bitonic sort.

A sort starts with a one-cycle `start` pulse while the block is idle. That pulse loads all N keys at once. `busy` stays high while the passes run. When the last pass has been written, `busy` drops and `done` rises in the same cycle. The sorted keys are then on `keys_out` in ascending order, and they stay there until the next accepted start.

Each merge step j (1..log2 N) has two parts. It first spends log2(N)-j passes with every cell set to pass through, which only realigns the data. It then spends j compare passes. In a compare pass the direction of a cell comes from one bit of its row number. In the final merge step every cell sends the minimum upward.

Top module: `srb_sorter`

## Requirements
- R1: While reset is high and after it is released, `busy` and `done` are 0 and every key on `keys_out` is 0.
- R2: A `start` sampled high while `busy` is 0 loads `keys_in` into the registers. In the following cycle `busy` is 1 and `done` is 0. This includes a start given while `done` is still high.
- R3: `done` rises, and `busy` falls, exactly log2(N)^2 clock edges after the edge that accepted the start. For N=8 that is 9 passes, so `done` is first seen high 10 cycles after `start` was driven.
- R4: When `done` is high, the keys are in ascending unsigned order. Key i sits at bits [i*W +: W] of `keys_out`, and key 0 is the smallest.
- R5: The sorted result is a permutation of the loaded keys. Duplicate values are kept with their full count.
- R6: A `start` pulse while `busy` is 1 is ignored. The running sort is not reloaded and its latency does not change.
- R7: Changes on `keys_in` after the accepting edge have no effect on the result of the running sort.
- R8: While idle with `start` low, `keys_out` and `done` hold their values, whatever `keys_in` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load the keys and begin a sort when idle |
| keys_in | input | N*W | Keys to sort; key i at [i*W +: W] |
| keys_out | output | N*W | Register contents; sorted ascending when done |
| busy | output | 1 | Passes in progress |
| done | output | 1 | Sort finished; held until the next accepted start |

## Verification
The bench tries all 256 two-valued key patterns for N=8. By the zero-one principle, a cell that gets the wrong direction bit or the wrong compare/pass-through choice leaves at least one of these patterns unsorted. Random keys, all-equal keys, reversed keys and heavily repeated keys catch a datapath that loses or duplicates a value. These cases also catch a shuffle that does not return to identity order, which would show up as a correct set of keys in the wrong positions. The bench counts the latency exactly, so a schedule that is one pass short or long is caught. It also pulses `start` and changes `keys_in` in the middle of a sort; a design that reloaded at that point would return the sorted second key set instead of the first.

// File: rtl/srb_pkg.sv
package srb_pkg;

  // Operating mode of one compare-exchange cell for the current pass.
  typedef enum logic [1:0] {
    CX_PASS = 2'd0,   // outputs equal inputs
    CX_DOWN = 2'd1,   // smaller key to the upper output
    CX_UP   = 2'd2    // smaller key to the lower output
  } cx_mode_t;

endpackage

// File: rtl/srb_sched.sv
// Pass sequencer: merge step counter and sub-pass counter.
module srb_sched #(
  parameter int LOGN = 3,
  parameter int SELW = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            launch,
  output logic            running,
  output logic            fin,
  output logic            cmp_pass,
  output logic            last_step,
  output logic [SELW-1:0] dir_sel
);

  localparam int JW = $clog2(LOGN + 1);
  localparam int SW = $clog2(LOGN);

  logic [JW-1:0] step_q;
  logic [SW-1:0] sub_q;
  int            sum_js;

  always_comb begin
    sum_js    = int'(step_q) + int'(sub_q);
    cmp_pass  = running && (sum_js >= LOGN);
    last_step = (int'(step_q) == LOGN);
    dir_sel   = SELW'(sum_js - LOGN);
    fin       = running && last_step && (int'(sub_q) == LOGN - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      step_q  <= JW'(1);
      sub_q   <= '0;
    end else if (launch) begin
      running <= 1'b1;
      step_q  <= JW'(1);
      sub_q   <= '0;
    end else if (running) begin
      if (int'(sub_q) == LOGN - 1) begin
        sub_q  <= '0;
        step_q <= step_q + JW'(1);
      end else begin
        sub_q <= sub_q + SW'(1);
      end
      if (fin) running <= 1'b0;
    end
  end

endmodule

// File: rtl/srb_mode_dec.sv
// Turns the pass descriptor into one mode per cell row.
module srb_mode_dec
  import srb_pkg::*;
#(
  parameter int HALF = 4,
  parameter int ROWW = 2,
  parameter int SELW = 1
) (
  input  logic            cmp_pass,
  input  logic            last_step,
  input  logic [SELW-1:0] dir_sel,
  output cx_mode_t        mode [HALF]
);

  for (genvar r = 0; r < HALF; r++) begin : g_row
    localparam logic [ROWW-1:0] ROWV = ROWW'(r);
    always_comb begin
      if (!cmp_pass)          mode[r] = CX_PASS;
      else if (last_step)     mode[r] = CX_DOWN;
      else if (ROWV[dir_sel]) mode[r] = CX_UP;
      else                    mode[r] = CX_DOWN;
    end
  end

endmodule

// File: rtl/srb_cx_elem.sv
// One two-input compare-exchange cell with selectable mode.
module srb_cx_elem
  import srb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] in_top,
  input  logic [W-1:0] in_bot,
  input  cx_mode_t     mode,
  output logic [W-1:0] out_top,
  output logic [W-1:0] out_bot
);

  logic          swap_lt;
  logic [W-1:0]  lo, hi;

  always_comb begin
    swap_lt = in_bot < in_top;
    lo = swap_lt ? in_bot : in_top;
    hi = swap_lt ? in_top : in_bot;
    unique case (mode)
      CX_DOWN: begin out_top = lo;     out_bot = hi;     end
      CX_UP:   begin out_top = hi;     out_bot = lo;     end
      default: begin out_top = in_top; out_bot = in_bot; end
    endcase
  end

endmodule

// File: rtl/srb_sorter.sv
// Recirculating bitonic sorter: N registers, N/2 cells, shuffle loop.
module srb_sorter
  import srb_pkg::*;
#(
  parameter int N = 8,   // power of two, at least 8
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N*W-1:0] keys_in,
  output logic [N*W-1:0] keys_out,
  output logic           busy,
  output logic           done
);

  localparam int LOGN = $clog2(N);
  localparam int HALF = N / 2;
  localparam int ROWW = LOGN - 1;
  localparam int SELW = $clog2(ROWW);

  logic            launch;
  logic            fin;
  logic            cmp_pass;
  logic            last_step;
  logic [SELW-1:0] dir_sel;
  cx_mode_t        mode [HALF];

  logic [W-1:0] key_q   [N];
  logic [W-1:0] shuf    [N];
  logic [W-1:0] cx_out  [N];

  assign launch = start && !busy;

  srb_sched #(.LOGN(LOGN), .SELW(SELW)) u_sched (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .running   (busy),
    .fin       (fin),
    .cmp_pass  (cmp_pass),
    .last_step (last_step),
    .dir_sel   (dir_sel)
  );

  srb_mode_dec #(.HALF(HALF), .ROWW(ROWW), .SELW(SELW)) u_dec (
    .cmp_pass  (cmp_pass),
    .last_step (last_step),
    .dir_sel   (dir_sel),
    .mode      (mode)
  );

  // Perfect shuffle: the key at position p moves to rotate-left(p).
  for (genvar q = 0; q < N; q++) begin : g_shuf
    localparam int SRC = (q >> 1) | ((q % 2) << (LOGN - 1));
    assign shuf[q] = key_q[SRC];
  end

  for (genvar r = 0; r < HALF; r++) begin : g_cx
    srb_cx_elem #(.W(W)) u_cx (
      .in_top  (shuf[2*r]),
      .in_bot  (shuf[2*r+1]),
      .mode    (mode[r]),
      .out_top (cx_out[2*r]),
      .out_bot (cx_out[2*r+1])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)         key_q[i] <= '0;
      else if (launch) key_q[i] <= keys_in[i*W +: W];
      else if (busy)   key_q[i] <= cx_out[i];
    end
    assign keys_out[i*W +: W] = key_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         done <= 1'b0;
    else if (launch) done <= 1'b0;
    else if (fin)    done <= 1'b1;
  end

endmodule

// File: rtl/srb_sorter_chk.sv
module srb_sorter_chk #(
  parameter int N = 8,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [N*W-1:0] keys_in,
  input logic [N*W-1:0] keys_out,
  input logic           busy,
  input logic           done
);

  localparam int LOGN   = $clog2(N);
  localparam int PASSES = LOGN * LOGN;
  localparam int SUMW   = W + LOGN;

  function automatic logic [SUMW-1:0] key_sum(input logic [N*W-1:0] v);
    logic [SUMW-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + SUMW'(v[i*W +: W]);
    return acc;
  endfunction

  logic [SUMW-1:0] held_sum;
  logic [31:0]     lat_cnt;
  logic            accept;

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_sum <= '0;
      lat_cnt  <= '0;
    end else if (accept) begin
      held_sum <= key_sum(keys_in);
      lat_cnt  <= '0;
    end else if (busy) begin
      lat_cnt  <= lat_cnt + 32'd1;
    end
  end

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !done));

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (lat_cnt == PASSES));

  a_r5_conserve: assert property (@(posedge clk) disable iff (rst)
    (busy || done) |-> (key_sum(keys_out) == held_sum));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(keys_out) && $stable(done)));

  for (genvar i = 0; i < N - 1; i++) begin : g_ord
    a_r4_ascending: assert property (@(posedge clk) disable iff (rst)
      done |-> (keys_out[i*W +: W] <= keys_out[(i+1)*W +: W]));
  end

endmodule

bind srb_sorter srb_sorter_chk #(.N(N), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .keys_in  (keys_in),
  .keys_out (keys_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_srb_sorter.sv
`timescale 1ns/1ps
module sim_srb_sorter;
  localparam int N = 8;
  localparam int W = 8;
  localparam int PASSES = 9;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N*W-1:0] keys_in = '0;
  logic [N*W-1:0] keys_out;
  logic           busy, done;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  srb_sorter #(.N(N), .W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .keys_in(keys_in),
    .keys_out(keys_out), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  // intrude: pulse start with other keys and keep keys_in changing mid-sort
  task automatic do_sort(input logic [N*W-1:0] vin, input bit intrude);
    int cyc;
    logic [N*W-1:0] exp;
    exp = ref_sort(vin);
    @(negedge clk); keys_in = vin; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !done, "R2 busy/done after start", {62'd0, busy, done}, 64'd2);
    cyc = 1;
    while (!done && cyc < 100) begin
      if (intrude && cyc == 3) begin start = 1'b1; keys_in = ~vin; end
      else if (intrude) begin start = 1'b0; keys_in = keys_in + 1; end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == PASSES + 1, intrude ? "R6 latency with start mid-sort" : "R3 latency",
          64'(cyc), 64'(PASSES + 1));
    check(keys_out == exp, intrude ? "R7 result ignores mid-sort inputs" : "R4 R5 sorted permutation",
          keys_out, exp);
  endtask

  initial begin
    #(200000 * 4);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [N*W-1:0] v, hold;
    logic hold_done;
    repeat (3) @(negedge clk);
    check(!busy && !done && keys_out == '0, "R1 reset state", keys_out, '0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && keys_out == '0, "R1 after reset", keys_out, '0);

    // R4 R5: every two-valued pattern (zero-one principle)
    for (int p = 0; p < 256; p++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = p[i] ? 8'hFF : 8'h00;
      do_sort(v, 1'b0);
    end
    // R4 R5: structured corner cases
    for (int i = 0; i < N; i++) v[i*W +: W] = 8'(N - 1 - i);
    do_sort(v, 1'b0);
    v = {N{8'h5A}};
    do_sort(v, 1'b0);
    for (int i = 0; i < N; i++) v[i*W +: W] = 8'(i % 3);
    do_sort(v, 1'b0);
    // R4 R5: random keys
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = 8'($urandom);
      do_sort(v, 1'b0);
    end
    // R6 R7: start pulse and input changes while busy
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = 8'($urandom);
      do_sort(v, 1'b1);
    end
    // R8: idle hold while keys_in moves
    hold = keys_out; hold_done = done;
    for (int k = 0; k < 6; k++) begin
      keys_in = 64'($urandom) << 32 | 64'($urandom);
      @(negedge clk);
      check(keys_out == hold && done == hold_done, "R8 idle hold", keys_out, hold);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule